// File: doc/BRIEF.md
# Two-Level Return Address Stack with Interrupt Hold-Off

This block keeps the return addresses of a small processor core. A subroutine call or an interrupt entry pushes the current program counter. A return from either one pops the saved value, and the core reloads its program counter from it. The contents and the fill level sit in hardware only, and software has no path to read or write them.

The stack has room for two addresses. When both slots are in use the block reports that it is full and withholds permission to take an interrupt. The pending request stays where the core keeps it, and the block grants permission again in the cycle after a return frees a slot. A call made while the stack is full is still accepted: the oldest saved address is discarded and the two newest remain. A return on an empty stack changes nothing and gives back whatever the bottom slot last held. When a push and a pop arrive in the same cycle, the pop is applied first.

Top module: `ret_stack`

## Requirements
- R1: After reset the stack is empty: `stackFull` is 0, both slots hold 0 and `retAddr` reads 0.
- R2: A push (`callReq`, or an accepted `intAck`) stores `pcIn` on top. While `popReq` is high, `retAddr` shows the top entry in that same cycle, and the pop removes that entry at the clock edge (last in, first out).
- R3: `stackFull` is 1 exactly when two entries are stored, and the fill level never exceeds two.
- R4: `intAckOk` equals `intPending` while the stack is not full and is 0 while it is full, combinationally in the same cycle.
- R5: An `intAck` while the stack is full, with no `popReq` and no `callReq` in that cycle, is ignored: the fill level and the contents do not change.
- R6: A pop on a full stack clears `stackFull` at the next edge, so a held interrupt gets `intAckOk` in the following cycle.
- R7: A `callReq` while the stack is full and `popReq` is low drops the oldest entry. The former top becomes the bottom, `pcIn` becomes the top, and the stack stays full.
- R8: A pop on an empty stack leaves the stack empty and drives `retAddr` with the bottom slot's last value.
- R9: A push together with a pop is applied as the pop followed by the push. The fill level is max(level−1,0)+1, and the new value replaces the popped top.
- R10: `callReq` and `intAck` in the same cycle push `pcIn` once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| callReq | input | 1 | Subroutine call: push `pcIn` |
| intAck | input | 1 | Interrupt entry: push `pcIn` if allowed |
| popReq | input | 1 | Return from subroutine or interrupt |
| intPending | input | 1 | An unmasked interrupt request is pending |
| pcIn | input | PC_W (10) | Program counter value to save |
| retAddr | output | PC_W (10) | Return address, valid while `popReq` is high |
| intAckOk | output | 1 | Interrupt may be acknowledged this cycle |
| stackFull | output | 1 | Both stack slots are occupied |

## Verification
The outputs `retAddr`, `intAckOk` and `stackFull` are combinational views of the stored state and the current inputs. A push or pop becomes visible on them in the cycle after the rising edge that applies it. The bench drives the inputs on the falling edge and samples the outputs one time step later, before the next rising edge. It updates its reference model only after that rising edge, so every comparison uses the state from before the operation. Held-interrupt release and overflow are checked in directed sequences, and a long random run covers interleaved push, pop and interrupt traffic.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;
  localparam int STACK_DEPTH = 2;
  localparam int IDX_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam int PTR_W = $clog2(STACK_DEPTH + 1);

  typedef struct packed {
    logic             wrEn;    // write pcIn into slot wrIdx
    logic             shiftDn; // overflow: slide entries down, pcIn on top
    logic [IDX_W-1:0] wrIdx;
    logic [IDX_W-1:0] rdIdx;   // slot shown on retAddr
  } stackStrobe_t;
endpackage

// File: rtl/ret_stack_ctrl.sv
module ret_stack_ctrl
  import ret_stack_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         callReq,
  input  logic         intAck,
  input  logic         popReq,
  input  logic         intPending,
  output stackStrobe_t strobe,
  output logic         stackFull,
  output logic         intAckOk
);
  logic [PTR_W-1:0] level, levelNext, afterPop;
  logic isEmpty, popDo, pushDo;

  always_comb begin
    stackFull = (level == PTR_W'(STACK_DEPTH));
    isEmpty   = (level == '0);
    intAckOk  = intPending && !stackFull;
    popDo     = popReq && !isEmpty;
    // an ack while full is only honoured if a pop frees a slot first
    pushDo    = callReq || (intAck && (!stackFull || popReq));
    afterPop  = popDo ? level - PTR_W'(1) : level;
    levelNext = afterPop;
    strobe    = '0;
    strobe.rdIdx = isEmpty ? '0 : IDX_W'(level - PTR_W'(1));
    if (pushDo) begin
      if (afterPop == PTR_W'(STACK_DEPTH)) begin
        strobe.shiftDn = 1'b1;
        strobe.wrIdx   = IDX_W'(STACK_DEPTH - 1);
      end else begin
        strobe.wrEn  = 1'b1;
        strobe.wrIdx = IDX_W'(afterPop);
        levelNext    = afterPop + PTR_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) level <= '0;
    else       level <= levelNext;
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    level <= PTR_W'(STACK_DEPTH)); // R3
  AST_HOLD_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    stackFull && intAck && !callReq && !popReq |=> stackFull); // R5
  AST_POP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    stackFull && popReq && !callReq && !intAck |=> !stackFull); // R6
  AST_OVERFLOW_FULL: assert property (@(posedge clk) disable iff (!rstN)
    stackFull && callReq && !popReq |=> stackFull); // R7
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rstN)
    isEmpty && popReq && !callReq && !intAck |=> level == '0); // R8
  AST_SWAP_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    !isEmpty && popReq && callReq |=> level == $past(level)); // R9
endmodule

// File: rtl/ret_stack_data.sv
module ret_stack_data
  import ret_stack_pkg::*;
#(
  parameter int PC_W = 10
) (
  input  logic         clk,
  input  logic         rstN,
  input  stackStrobe_t strobe,
  input  logic [PC_W-1:0] pcIn,
  output logic [PC_W-1:0] retAddr
);
  logic [PC_W-1:0] slot [STACK_DEPTH];

  for (genvar i = 0; i < STACK_DEPTH; i++) begin : g_slot
    if (i == STACK_DEPTH - 1) begin : g_top
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) slot[i] <= '0;
        else if (strobe.shiftDn || (strobe.wrEn && strobe.wrIdx == IDX_W'(i)))
          slot[i] <= pcIn;
      end
    end else begin : g_low
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) slot[i] <= '0;
        else if (strobe.shiftDn) slot[i] <= slot[i+1];
        else if (strobe.wrEn && strobe.wrIdx == IDX_W'(i)) slot[i] <= pcIn;
      end
    end
  end

  assign retAddr = slot[strobe.rdIdx];

  AST_SHIFT_NEWEST: assert property (@(posedge clk) disable iff (!rstN)
    strobe.shiftDn |=> slot[STACK_DEPTH-1] == $past(pcIn)); // R7
  if (STACK_DEPTH >= 2) begin : g_shift_chk
    AST_SHIFT_DROPS_OLDEST: assert property (@(posedge clk) disable iff (!rstN)
      strobe.shiftDn |=> slot[STACK_DEPTH-2] == $past(slot[STACK_DEPTH-1])); // R7
  end
endmodule

// File: rtl/ret_stack.sv
module ret_stack
  import ret_stack_pkg::*;
#(
  parameter int PC_W = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            callReq,
  input  logic            intAck,
  input  logic            popReq,
  input  logic            intPending,
  input  logic [PC_W-1:0] pcIn,
  output logic [PC_W-1:0] retAddr,
  output logic            intAckOk,
  output logic            stackFull
);
  stackStrobe_t strobe;

  ret_stack_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .callReq(callReq), .intAck(intAck),
    .popReq(popReq), .intPending(intPending), .strobe(strobe),
    .stackFull(stackFull), .intAckOk(intAckOk)
  );

  ret_stack_data #(.PC_W(PC_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pcIn(pcIn), .retAddr(retAddr)
  );
endmodule

// File: tb/sim_ret_stack.sv
module sim_ret_stack;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 10;

  logic clk = 1'b0, rstN = 1'b0;
  logic callReq = 0, intAck = 0, popReq = 0, intPending = 0;
  logic [PC_W-1:0] pcIn = '0;
  logic [PC_W-1:0] retAddr;
  logic intAckOk, stackFull;

  int checks = 0, errors = 0;
  logic [PC_W-1:0] m0 = '0, m1 = '0;
  int lvl = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ret_stack #(.PC_W(PC_W)) u0 (
    .clk(clk), .rstN(rstN), .callReq(callReq), .intAck(intAck),
    .popReq(popReq), .intPending(intPending), .pcIn(pcIn),
    .retAddr(retAddr), .intAckOk(intAckOk), .stackFull(stackFull)
  );

  function automatic logic [PC_W-1:0] expRet();
    return (lvl == 0) ? m0 : ((lvl == 1) ? m0 : m1);
  endfunction
  function automatic logic expAck(logic pend);
    return pend && (lvl != 2);
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic c, logic a, logic p, logic pend,
                      logic [PC_W-1:0] pc);
    int pushDo, popDo;
    @(negedge clk);
    callReq = c; intAck = a; popReq = p; intPending = pend; pcIn = pc;
    #1;
    chk(tag, "retAddr", retAddr, expRet());
    chk((lvl == 2) ? "R4" : tag, "intAckOk", intAckOk, expAck(pend));
    chk("R3", "stackFull", stackFull, lvl == 2);
    @(posedge clk);
    pushDo = c || (a && (lvl != 2 || p));
    popDo  = p && lvl > 0;
    if (popDo) lvl--;
    if (pushDo) begin
      if (lvl == 2) begin m0 = m1; m1 = pc; end
      else begin
        if (lvl == 0) m0 = pc; else m1 = pc;
        lvl++;
      end
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (2) @(negedge clk);
    #1;
    chk("R1", "retAddr reset", retAddr, 0);
    chk("R1", "stackFull reset", stackFull, 0);
    rstN = 1'b1;
    step("R1", 0, 0, 0, 1, 10'h155);
    step("R2", 1, 0, 0, 0, 10'h101);       // push A
    step("R2", 1, 0, 0, 1, 10'h202);       // push B -> full
    step("R5", 0, 1, 0, 1, 10'h3ff);       // ack while full: ignored
    step("R5", 0, 0, 1, 1, 10'h000);       // pop returns B
    step("R6", 0, 0, 0, 1, 10'h000);       // ack allowed again
    step("R2", 0, 0, 1, 0, 10'h000);       // pop returns A
    step("R8", 0, 0, 1, 0, 10'h000);       // empty pop, bottom value
    step("R8", 0, 0, 0, 0, 10'h000);
    step("R7", 1, 0, 0, 0, 10'h011);
    step("R7", 1, 0, 0, 0, 10'h022);
    step("R7", 1, 0, 0, 0, 10'h033);       // overflow drops 0x011
    step("R7", 0, 0, 1, 0, 10'h000);       // returns 0x033
    step("R7", 0, 0, 1, 0, 10'h000);       // returns 0x022
    step("R8", 0, 0, 1, 0, 10'h000);       // empty
    step("R9", 1, 0, 1, 0, 10'h044);       // empty pop + push
    step("R9", 1, 0, 1, 0, 10'h055);       // replaces top
    step("R9", 0, 0, 1, 0, 10'h000);       // returns 0x055
    step("R10", 1, 1, 0, 1, 10'h066);      // single push
    step("R10", 0, 0, 1, 1, 10'h000);      // returns 0x066
    step("R10", 0, 0, 0, 1, 10'h000);      // level 0 again
    step("R5", 1, 0, 0, 0, 10'h077);
    step("R5", 1, 0, 0, 0, 10'h088);
    step("R5", 0, 1, 1, 1, 10'h099);       // ack with pop while full: accepted
    step("R5", 0, 0, 1, 0, 10'h000);       // returns 0x099
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      step("R2", r < 3, r >= 7 || r == 3, r >= 4 && r <= 7,
           1'($urandom_range(0, 1)), PC_W'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule